// File: doc/BRIEF.md
# Speech Processor I/O Port Glue

This block is the address-decode and register glue between an 8-bit microcontroller and a parallel speech-synthesis chip. It decodes the controller's I/O space into three ports.

- **Strobe register.** It holds the speech chip's two active-low select lines: one for write-select and one for read-select.
- **Data port.** A write latches a byte onto the speech chip's data bus. A read returns the chip's status byte.
- **Control/status port.** A read returns the last byte written to it, except that three bit positions carry live inputs: a receive-FIFO-not-empty flag and the speech chip's active-low interrupt and ready lines.

The block also decodes program-memory reads. Addresses in the low 8 KB select the ROM and pass its data through. Every other program address reads as open bus (all ones).

The controller drives an I/O address, a write strobe, a read strobe and write data. Register updates happen on the clock edge at which the write strobe is high. Read data is combinational from the current register contents and the live inputs. The speech chip, the ROM array and the serial line drivers sit outside the block and appear only as ports.

Top module: `vio_glue`

## Requirements
- R1: While reset is held, and after it is released, both select outputs `ws_n` and `rs_n` are 1, and both `ctrl_q` and `sp_dbus` are 0x00.
- R2: A write to I/O address 0x00 loads data bit 0 into `ws_n` and data bit 1 into `rs_n`, effective at that clock edge.
- R3: A write to I/O address 0x01 latches the byte on `sp_dbus`. A read of address 0x01 returns `sp_status`.
- R4: A read of I/O address 0x03 returns `ctrl_q & 0xE3`, with bit 2 = `sp_int_n`, bit 3 = `sp_rdy_n` and bit 4 = `fifo_nonempty`.
- R5: A write to I/O address 0x03 stores all eight data bits in `ctrl_q`.
- R6: Only the low 8 bits of `io_addr` are decoded, so 0x0100 acts as 0x00 and 0x0301 acts as 0x01.
- R7: A write to any other I/O address, or a cycle with `io_wr` low, changes no register. A read of any address other than 0x01 or 0x03, including 0x00, returns 0xFF. `io_rdata` is 0xFF whenever `io_rd` is low.
- R8: A program address below 0x2000 sets `rom_sel` to 1 and `prog_rdata` equals `rom_data`. Any other program address gives `rom_sel` 0 and `prog_rdata` 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address (low 8 bits decoded) |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| prog_addr | input | 16 | Program memory address |
| rom_data | input | 8 | Byte from the ROM array |
| rom_sel | output | 1 | ROM select |
| prog_rdata | output | 8 | Program read data |
| sp_status | input | 8 | Speech chip status byte |
| sp_int_n | input | 1 | Speech chip interrupt, active low |
| sp_rdy_n | input | 1 | Speech chip ready, active low |
| fifo_nonempty | input | 1 | Receive FIFO holds data |
| sp_dbus | output | 8 | Latched speech chip data bus |
| ws_n | output | 1 | Speech chip write-select, active low |
| rs_n | output | 1 | Speech chip read-select, active low |
| ctrl_q | output | 8 | Stored control-port byte |

## Verification
The strobe port is exercised with all four combinations of bits 1:0, so a swapped or stuck select line shows up. The status read is tried with an all-ones stored byte and different live inputs, and with a stored byte that is ones only in the live positions. Together these separate a masking error from a merging error and reveal a misplaced live bit. Aliased high addresses, unmapped addresses and idle-strobe cycles show whether decoding uses only the low byte and leaves registers untouched. Program addresses on both sides of the 8 KB boundary check the ROM window edge.

// File: rtl/vio_pkg.sv
// Package: shared constants and types for the speech I/O glue.
// Assumes an 8-bit data path; addresses are compared on the low byte only.
package vio_pkg;
    localparam int DATA_W = 8;
    localparam int DEC_W  = 8;

    localparam logic [DEC_W-1:0] STROBE_ADDR = 8'h00;
    localparam logic [DEC_W-1:0] DATA_ADDR   = 8'h01;
    localparam logic [DEC_W-1:0] CTRL_ADDR   = 8'h03;

    // bit positions inside the strobe and control bytes
    localparam int WS_BIT   = 0;
    localparam int RS_BIT   = 1;
    localparam int INT_BIT  = 2;
    localparam int RDY_BIT  = 3;
    localparam int FIFO_BIT = 4;

    localparam logic [DATA_W-1:0] OPEN_BUS = '1;

    typedef enum logic [1:0] {
        PORT_NONE   = 2'd0,
        PORT_STROBE = 2'd1,
        PORT_DATA   = 2'd2,
        PORT_CTRL   = 2'd3
    } port_sel_e;
endpackage

// File: rtl/vio_addr_dec.sv
// Address decoder: maps the low byte of the I/O address to a port selector.
// Assumes IO_ADDR_W >= 8; upper address bits are deliberately ignored.
module vio_addr_dec
    import vio_pkg::*;
#(
    parameter int IO_ADDR_W = 16
) (
    input  logic [IO_ADDR_W-1:0] io_addr,
    output port_sel_e            sel
);
    localparam int HI_W = IO_ADDR_W - DEC_W;

    logic [DEC_W-1:0] low_addr;
    assign low_addr = io_addr[DEC_W-1:0];

    generate
        if (HI_W > 0) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^io_addr[IO_ADDR_W-1:DEC_W];
        end
    endgenerate

    // Purpose: pick the port addressed by the low byte.
    always_comb begin
        unique case (low_addr)
            STROBE_ADDR: sel = PORT_STROBE;
            DATA_ADDR:   sel = PORT_DATA;
            CTRL_ADDR:   sel = PORT_CTRL;
            default:     sel = PORT_NONE;
        endcase
    end
endmodule

// File: rtl/vio_regs.sv
// Register bank: select strobes, speech data latch and control byte.
// Assumes a single write per cycle; updates only when wr is high.
module vio_regs
    import vio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  port_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              ws_n,
    output logic              rs_n,
    output logic [DATA_W-1:0] sp_dbus,
    output logic [DATA_W-1:0] ctrl_q
);
    // Purpose: load the active-low select lines from the strobe port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_n <= 1'b1;
            rs_n <= 1'b1;
        end else if (wr && sel == PORT_STROBE) begin
            ws_n <= wdata[WS_BIT];
            rs_n <= wdata[RS_BIT];
        end
    end

    // Purpose: latch the byte driven to the speech chip data bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_dbus <= '0;
        else if (wr && sel == PORT_DATA)
            sp_dbus <= wdata;
    end

    // Purpose: store the last byte written to the control port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr && sel == PORT_CTRL)
            ctrl_q <= wdata;
    end
endmodule

// File: rtl/vio_read_mux.sv
// Read multiplexer: returns status, merged control byte, or open bus.
// Assumes combinational reads; idle cycles return all ones.
module vio_read_mux
    import vio_pkg::*;
(
    input  logic              rd,
    input  port_sel_e         sel,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] sp_status,
    input  logic              sp_int_n,
    input  logic              sp_rdy_n,
    input  logic              fifo_nonempty,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] live_mask;
    logic [DATA_W-1:0] live_bits;

    // Purpose: place the three live inputs at their bit positions.
    always_comb begin
        live_mask           = '0;
        live_mask[INT_BIT]  = 1'b1;
        live_mask[RDY_BIT]  = 1'b1;
        live_mask[FIFO_BIT] = 1'b1;
        live_bits           = '0;
        live_bits[INT_BIT]  = sp_int_n;
        live_bits[RDY_BIT]  = sp_rdy_n;
        live_bits[FIFO_BIT] = fifo_nonempty;
    end

    // Purpose: choose the read value for the addressed port.
    always_comb begin
        rdata = OPEN_BUS;
        if (rd) begin
            unique case (sel)
                PORT_DATA: rdata = sp_status;
                PORT_CTRL: rdata = (ctrl_q & ~live_mask) | live_bits;
                default:   rdata = OPEN_BUS;
            endcase
        end
    end
endmodule

// File: rtl/vio_prog_dec.sv
// Program memory decoder: ROM window at the bottom, open bus above.
// Assumes ROM_BYTES is a power of two smaller than the address space.
module vio_prog_dec
    import vio_pkg::*;
#(
    parameter int PROG_ADDR_W = 16,
    parameter int ROM_BYTES   = 8192
) (
    input  logic [PROG_ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0]      rom_data,
    output logic                   rom_sel,
    output logic [DATA_W-1:0]      prog_rdata
);
    localparam int ROM_AW = $clog2(ROM_BYTES);

    logic unused_lo;
    assign unused_lo = ^prog_addr[ROM_AW-1:0];

    // Purpose: select ROM when all bits above the window are zero.
    always_comb begin
        rom_sel    = (prog_addr[PROG_ADDR_W-1:ROM_AW] == '0);
        prog_rdata = rom_sel ? rom_data : OPEN_BUS;
    end
endmodule

// File: rtl/vio_glue.sv
// Top: speech processor I/O glue. Decodes controller I/O and program
// space, holds the select strobes, data latch and control byte.
// Assumes synchronous active-low reset and one access per cycle.
module vio_glue #(
    parameter int IO_ADDR_W   = 16,
    parameter int PROG_ADDR_W = 16,
    parameter int ROM_BYTES   = 8192
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IO_ADDR_W-1:0]   io_addr,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [7:0]             io_wdata,
    output logic [7:0]             io_rdata,
    input  logic [PROG_ADDR_W-1:0] prog_addr,
    input  logic [7:0]             rom_data,
    output logic                   rom_sel,
    output logic [7:0]             prog_rdata,
    input  logic [7:0]             sp_status,
    input  logic                   sp_int_n,
    input  logic                   sp_rdy_n,
    input  logic                   fifo_nonempty,
    output logic [7:0]             sp_dbus,
    output logic                   ws_n,
    output logic                   rs_n,
    output logic [7:0]             ctrl_q
);
    import vio_pkg::*;

    port_sel_e sel;

    vio_addr_dec #(.IO_ADDR_W(IO_ADDR_W)) u_dec (
        .io_addr (io_addr),
        .sel     (sel)
    );

    vio_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (io_wr),
        .sel     (sel),
        .wdata   (io_wdata),
        .ws_n    (ws_n),
        .rs_n    (rs_n),
        .sp_dbus (sp_dbus),
        .ctrl_q  (ctrl_q)
    );

    vio_read_mux u_rmux (
        .rd            (io_rd),
        .sel           (sel),
        .ctrl_q        (ctrl_q),
        .sp_status     (sp_status),
        .sp_int_n      (sp_int_n),
        .sp_rdy_n      (sp_rdy_n),
        .fifo_nonempty (fifo_nonempty),
        .rdata         (io_rdata)
    );

    vio_prog_dec #(.PROG_ADDR_W(PROG_ADDR_W), .ROM_BYTES(ROM_BYTES)) u_pdec (
        .prog_addr  (prog_addr),
        .rom_data   (rom_data),
        .rom_sel    (rom_sel),
        .prog_rdata (prog_rdata)
    );
endmodule

// File: rtl/vio_glue_chk.sv
// Checker: port-level properties of the speech I/O glue, bound to the top.
module vio_glue_chk #(
    parameter int IO_ADDR_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IO_ADDR_W-1:0] io_addr,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic [7:0]           rom_data,
    input logic                 rom_sel,
    input logic [7:0]           prog_rdata,
    input logic [7:0]           sp_status,
    input logic                 sp_int_n,
    input logic                 sp_rdy_n,
    input logic                 fifo_nonempty,
    input logic [7:0]           sp_dbus,
    input logic                 ws_n,
    input logic                 rs_n,
    input logic [7:0]           ctrl_q
);
    logic [7:0] la;
    assign la = io_addr[7:0];

    AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && la == 8'h00) |=> (ws_n == $past(io_wdata[0]) && rs_n == $past(io_wdata[1]))); // R2
    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && la == 8'h00) |=> ($stable(ws_n) && $stable(rs_n))); // R7
    AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && la == 8'h01) |=> (sp_dbus == $past(io_wdata))); // R3
    AST_CTRL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && la == 8'h03) |=> (ctrl_q == $past(io_wdata))); // R5
    AST_LIVE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && la == 8'h03) |-> (io_rdata[4] == fifo_nonempty && io_rdata[3] == sp_rdy_n
                                   && io_rdata[2] == sp_int_n)); // R4
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && la == 8'h01) |-> (io_rdata == sp_status)); // R3
    AST_OPEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd || (la != 8'h01 && la != 8'h03)) |-> (io_rdata == 8'hFF)); // R7
    AST_ROM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (prog_rdata == rom_data)); // R8
    AST_ROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (prog_rdata == 8'hFF)); // R8
endmodule

bind vio_glue vio_glue_chk #(.IO_ADDR_W(IO_ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_addr       (io_addr),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .io_wdata      (io_wdata),
    .io_rdata      (io_rdata),
    .rom_data      (rom_data),
    .rom_sel       (rom_sel),
    .prog_rdata    (prog_rdata),
    .sp_status     (sp_status),
    .sp_int_n      (sp_int_n),
    .sp_rdy_n      (sp_rdy_n),
    .fifo_nonempty (fifo_nonempty),
    .sp_dbus       (sp_dbus),
    .ws_n          (ws_n),
    .rs_n          (rs_n),
    .ctrl_q        (ctrl_q)
);

// File: tb/vio_glue_tb.sv
// Directed bench for the speech I/O glue: one task per scenario.
module vio_glue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [15:0] prog_addr = '0;
    logic [7:0]  rom_data = '0;
    logic        rom_sel;
    logic [7:0]  prog_rdata;
    logic [7:0]  sp_status = '0;
    logic        sp_int_n = 1'b0;
    logic        sp_rdy_n = 1'b0;
    logic        fifo_nonempty = 1'b0;
    logic [7:0]  sp_dbus;
    logic        ws_n;
    logic        rs_n;
    logic [7:0]  ctrl_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vio_glue u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .prog_addr(prog_addr),
        .rom_data(rom_data), .rom_sel(rom_sel), .prog_rdata(prog_rdata),
        .sp_status(sp_status), .sp_int_n(sp_int_n), .sp_rdy_n(sp_rdy_n),
        .fifo_nonempty(fifo_nonempty), .sp_dbus(sp_dbus), .ws_n(ws_n),
        .rs_n(rs_n), .ctrl_q(ctrl_q)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // one write cycle; the register updates at the edge inside it
    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        repeat (3) @(negedge clk);
        check("R1 ws_n in reset", {15'd0, ws_n}, 16'd1);
        check("R1 rs_n in reset", {15'd0, rs_n}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctrl_q after reset", {8'd0, ctrl_q}, 16'h00);
        check("R1 sp_dbus after reset", {8'd0, sp_dbus}, 16'h00);
        io_read(16'h0003, r);
        check("R1 ctrl read after reset", {8'd0, r}, 16'h00);
    endtask

    task automatic t_strobe();
        for (int v = 0; v < 4; v++) begin
            io_write(16'h0000, 8'(v) | 8'hF0);
            check("R2 ws_n", {15'd0, ws_n}, {15'd0, v[0]});
            check("R2 rs_n", {15'd0, rs_n}, {15'd0, v[1]});
        end
    endtask

    task automatic t_data();
        logic [7:0] r;
        io_write(16'h0001, 8'hA5);
        check("R3 sp_dbus", {8'd0, sp_dbus}, 16'h00A5);
        sp_status = 8'h3C;
        io_read(16'h0001, r);
        check("R3 status read", {8'd0, r}, 16'h003C);
    endtask

    task automatic t_ctrl();
        logic [7:0] r;
        io_write(16'h0003, 8'hFF);
        check("R5 ctrl_q store", {8'd0, ctrl_q}, 16'h00FF);
        fifo_nonempty = 0; sp_int_n = 0; sp_rdy_n = 0;
        io_read(16'h0003, r);
        check("R4 mask all live low", {8'd0, r}, 16'h00E3);
        fifo_nonempty = 1;
        io_read(16'h0003, r);
        check("R4 fifo bit", {8'd0, r}, 16'h00F3);
        fifo_nonempty = 0; sp_int_n = 1;
        io_read(16'h0003, r);
        check("R4 int bit", {8'd0, r}, 16'h00E7);
        sp_int_n = 0; sp_rdy_n = 1;
        io_read(16'h0003, r);
        check("R4 rdy bit", {8'd0, r}, 16'h00EB);
        sp_rdy_n = 0;
        io_write(16'h0003, 8'h1C);
        check("R5 ctrl_q 0x1C", {8'd0, ctrl_q}, 16'h001C);
        io_read(16'h0003, r);
        check("R4 stored live bits hidden", {8'd0, r}, 16'h0000);
    endtask

    task automatic t_alias();
        logic [7:0] r;
        io_write(16'h0000, 8'h00);
        io_write(16'h0100, 8'h03);
        check("R6 alias ws_n", {15'd0, ws_n}, 16'd1);
        check("R6 alias rs_n", {15'd0, rs_n}, 16'd1);
        sp_status = 8'h96;
        io_read(16'h0301, r);
        check("R6 alias status", {8'd0, r}, 16'h0096);
    endtask

    task automatic t_unmapped();
        logic [7:0] r;
        io_write(16'h0000, 8'h02);
        io_write(16'h0001, 8'h11);
        io_write(16'h0003, 8'h40);
        io_write(16'h0002, 8'h00);
        io_write(16'h00FF, 8'hFF);
        io_write(16'h0004, 8'h01);
        check("R7 ws_n untouched", {15'd0, ws_n}, 16'd0);
        check("R7 rs_n untouched", {15'd0, rs_n}, 16'd1);
        check("R7 sp_dbus untouched", {8'd0, sp_dbus}, 16'h0011);
        check("R7 ctrl_q untouched", {8'd0, ctrl_q}, 16'h0040);
        // strobe held low: a decoded address must not load
        @(negedge clk);
        io_addr = 16'h0003; io_wdata = 8'h99;
        @(negedge clk);
        check("R7 no write without strobe", {8'd0, ctrl_q}, 16'h0040);
        check("R7 idle read is open bus", {8'd0, io_rdata}, 16'h00FF);
        io_read(16'h0002, r);
        check("R7 read addr 2", {8'd0, r}, 16'h00FF);
        io_read(16'h0000, r);
        check("R7 read addr 0", {8'd0, r}, 16'h00FF);
    endtask

    task automatic t_prog();
        @(negedge clk);
        rom_data = 8'h5A; prog_addr = 16'h0000;
        #1;
        check("R8 sel at 0x0000", {15'd0, rom_sel}, 16'd1);
        check("R8 data at 0x0000", {8'd0, prog_rdata}, 16'h005A);
        prog_addr = 16'h1FFF;
        #1;
        check("R8 data at 0x1FFF", {8'd0, prog_rdata}, 16'h005A);
        prog_addr = 16'h2000;
        #1;
        check("R8 sel at 0x2000", {15'd0, rom_sel}, 16'd0);
        check("R8 data at 0x2000", {8'd0, prog_rdata}, 16'h00FF);
        prog_addr = 16'hFFFF;
        #1;
        check("R8 data at 0xFFFF", {8'd0, prog_rdata}, 16'h00FF);
    endtask

    initial begin
        t_reset();
        t_strobe();
        t_data();
        t_ctrl();
        t_alias();
        t_unmapped();
        t_prog();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        #5;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule